// File: doc/BRIEF.md
# Two-Wire Single-Byte Register Slave

This block is a slave on a two-wire serial bus (an open-drain clock line and an open-drain data line, framed like I2C). It lets a bus master write or read exactly one 8-bit register per transaction. Two device addresses are decoded. One reaches the block's own register bank. The other reaches an attached sensor register bank through this slave. Each target owns one half of the 8-bit sub-address space. The slave turns every accepted access into a single strobe on a parallel register port. That port carries a target select, the sub-address, write data, a write strobe, a read strobe and returned read data.

Both bus lines are sampled into the system clock domain through a synchroniser chain. All protocol decisions are taken on the synchronised copies. The slave never drives a line high. It only asserts `sda_oe`, which pulls the data line low. A write sends the device address, the sub-address and one data byte. A read first sends the device address with a write bit and the sub-address, then a repeated start, then the device address with a read bit. It ends after one returned byte, which the master answers with a NACK.

Top module: `twr_reg_slave`

## Requirements
- R1: After reset `sda_oe`, `reg_we` and `reg_re` are all 0.
- R2: A start (data falling while clock is high) or a stop (data rising while clock is high) is recognised at any point. When either arrives in the middle of a byte, that transaction is abandoned and issues no register strobe. The next transaction then behaves normally.
- R3: The address byte selects a target from its upper 7 bits, and bit 0 is the read/write flag (1 = read). Value 7'h20 selects the internal bank (`reg_sel` = 0). Value 7'h11 selects the sensor bank (`reg_sel` = 1). Any other value gets no acknowledge.
- R4: The internal bank accepts sub-addresses 80h..FFh and the sensor bank accepts 00h..7Fh. A sub-address outside the addressed target's range is not acknowledged, and no strobe follows.
- R5: An accepted address byte, sub-address byte or write data byte is acknowledged by holding the data line low for the whole ninth clock pulse.
- R6: A write produces exactly one `reg_we` pulse, one system clock wide, after the ninth clock of the data byte ends. During that pulse `reg_sel`, `reg_addr` and `reg_wdata` carry the target, the sub-address and the data byte.
- R7: Only one data byte is taken per transaction. A further byte before stop gets no acknowledge and causes no strobe.
- R8: After a repeated start, an accepted read address gives one `reg_re` pulse, one clock wide, with `reg_sel` and `reg_addr` valid. `reg_rdata` is taken in that cycle and sent MSB first on the 8 clocks that follow the acknowledge.
- R9: `sda_oe` changes only while the synchronised clock line is low.
- R10: A read address that is not preceded, in the same transaction, by an accepted sub-address gets no acknowledge and no `reg_re`. After the read byte, the slave leaves the data line released through the master's NACK clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_sel | output | 1 | Target: 0 internal bank, 1 sensor bank |
| reg_addr | output | 8 | Register sub-address |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_re | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_re` is high |

## Verification
Two events can coincide in one system clock. The first is the write strobe that closes a data byte. The second is an abort from a start or stop condition that arrives in the same transaction. The bench provokes this by cutting a data byte off partway with a stop, and by following a completed write at once with a stop. In the first case no `reg_we` may appear. In the second exactly one must appear, with the right target, address and data. Random transactions over valid and invalid device addresses and both halves of the sub-address space are compared against a bench model of both banks and the acknowledge rules.

// File: rtl/twr_pkg.sv
package twr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_SUB,
      ST_WDAT,
      ST_ACKD,
      ST_ACKH,
      ST_RDAT,
      ST_HOLD
   } twr_state_e;

   typedef enum logic {
      TGT_INT = 1'b0,
      TGT_SNS = 1'b1
   } twr_tgt_e;

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   if (STAGES < 2) begin : g_bad_stages
      $error("twr_line_sync needs at least two stages");
   end

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   // idle bus is high, so the chain resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twr_addr_decode.sv
module twr_addr_decode
   import twr_pkg::*;
#(
   parameter int              DEV_W   = 7,
   parameter int              ADDR_W  = 8,
   parameter logic [DEV_W-1:0] INT_DEV = 7'h20,
   parameter logic [DEV_W-1:0] SNS_DEV = 7'h11,
   parameter int              INT_LO  = 'h80,
   parameter int              INT_HI  = 'hFF,
   parameter int              SNS_LO  = 'h00,
   parameter int              SNS_HI  = 'h7F
) (
   input  logic [DEV_W-1:0]  dev_in,
   input  logic [ADDR_W-1:0] sub_in,
   output logic              dev_hit,
   output twr_tgt_e          dev_tgt,
   output logic [1:0]        win_ok
);

   localparam int ADDR_MAX = (1 << ADDR_W) - 1;

   if (INT_DEV == SNS_DEV) begin : g_bad_dev
      $error("the two device addresses must differ");
   end

   assign dev_hit = (dev_in == INT_DEV) || (dev_in == SNS_DEV);
   assign dev_tgt = (dev_in == SNS_DEV) ? TGT_SNS : TGT_INT;

   // one window per target; bounds at the edge of the space need no compare
   for (genvar t = 0; t < 2; t++) begin : g_win
      localparam int LO = (t == 0) ? INT_LO : SNS_LO;
      localparam int HI = (t == 0) ? INT_HI : SNS_HI;
      logic lo_ok;
      logic hi_ok;
      if (LO == 0) begin : g_nolo
         assign lo_ok = 1'b1;
      end else begin : g_lo
         assign lo_ok = (sub_in >= ADDR_W'(LO));
      end
      if (HI >= ADDR_MAX) begin : g_nohi
         assign hi_ok = 1'b1;
      end else begin : g_hi
         assign hi_ok = (sub_in <= ADDR_W'(HI));
      end
      assign win_ok[t] = lo_ok & hi_ok;
   end

endmodule

// File: rtl/twr_byte_engine.sv
module twr_byte_engine
   import twr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEV_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_p,
   input  logic              stop_p,
   // decoder side
   output logic [DEV_W-1:0]  dec_dev,
   output logic [DATA_W-1:0] dec_sub,
   input  logic              dev_hit,
   input  twr_tgt_e          dev_tgt,
   input  logic [1:0]        win_ok,
   // register port
   output logic              sda_oe,
   output logic              reg_sel,
   output logic [DATA_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam int BIT_W = $clog2(DATA_W);

   twr_state_e        state;
   twr_state_e        nxt_q;
   twr_state_e        byte_nxt;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] byte_now;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] sub_q;
   logic [DATA_W-1:0] wdata_q;
   twr_tgt_e          tgt_q;
   logic              ack_q;
   logic              sub_vld;
   logic              wr_pend;
   logic              byte_ok;
   logic              rw_bit;
   logic              last_bit;

   assign byte_now = {sh[DATA_W-2:0], sda_s};
   assign rw_bit   = sda_s;
   assign last_bit = (cnt == CNT_W'(DATA_W - 1));
   assign dec_dev  = byte_now[DATA_W-1:1];
   assign dec_sub  = (state == ST_SUB) ? byte_now : sub_q;

   // acceptance of the byte that completes at this clock rise
   always_comb begin
      byte_ok  = 1'b0;
      byte_nxt = ST_HOLD;
      unique case (state)
         ST_DEV: begin
            byte_ok  = dev_hit && (!rw_bit || (sub_vld && win_ok[dev_tgt]));
            byte_nxt = rw_bit ? ST_RDAT : ST_SUB;
         end
         ST_SUB: begin
            byte_ok  = win_ok[tgt_q];
            byte_nxt = ST_WDAT;
         end
         ST_WDAT: begin
            byte_ok  = 1'b1;
            byte_nxt = ST_HOLD;
         end
         default: begin
            byte_ok  = 1'b0;
            byte_nxt = ST_HOLD;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         nxt_q   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         rd_q    <= '0;
         sub_q   <= '0;
         wdata_q <= '0;
         tgt_q   <= TGT_INT;
         ack_q   <= 1'b0;
         sub_vld <= 1'b0;
         wr_pend <= 1'b0;
         sda_oe  <= 1'b0;
         reg_we  <= 1'b0;
         reg_re  <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         if (reg_re) begin
            rd_q <= reg_rdata;
         end
         if (stop_p) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            sub_vld <= 1'b0;
            wr_pend <= 1'b0;
         end else if (start_p) begin
            state   <= ST_DEV;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            wr_pend <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_SUB, ST_WDAT: begin
                  if (scl_rise) begin
                     sh  <= byte_now;
                     cnt <= cnt + 1'b1;
                     if (last_bit) begin
                        state <= ST_ACKD;
                        ack_q <= byte_ok;
                        nxt_q <= byte_nxt;
                        if (state == ST_DEV && byte_ok) begin
                           tgt_q <= dev_tgt;
                           if (rw_bit) begin
                              reg_re <= 1'b1;
                           end else begin
                              sub_vld <= 1'b0;
                           end
                        end
                        if (state == ST_SUB && byte_ok) begin
                           sub_q   <= byte_now;
                           sub_vld <= 1'b1;
                        end
                        if (state == ST_WDAT) begin
                           wdata_q <= byte_now;
                           wr_pend <= 1'b1;
                        end
                     end
                  end
               end
               ST_ACKD: begin
                  if (scl_fall) begin
                     sda_oe <= ack_q;
                     state  <= ack_q ? ST_ACKH : ST_HOLD;
                  end
               end
               ST_ACKH: begin
                  if (scl_fall) begin
                     state  <= nxt_q;
                     cnt    <= '0;
                     sda_oe <= (nxt_q == ST_RDAT) ? ~rd_q[DATA_W-1] : 1'b0;
                     if (wr_pend) begin
                        reg_we  <= 1'b1;
                        wr_pend <= 1'b0;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_W'(DATA_W)) begin
                        sda_oe <= 1'b0;
                        state  <= ST_HOLD;
                     end else begin
                        sda_oe <= ~rd_q[BIT_W'(DATA_W - 1) - cnt[BIT_W-1:0]];
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign reg_sel   = tgt_q;
   assign reg_addr  = sub_q;
   assign reg_wdata = wdata_q;

   // R6: write strobe lasts one clock
   p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R8: read strobe lasts one clock
   p_re_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R6 / R8: never both strobes together
   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   // R9: data drive moves only while the clock line is low
   p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_s));

   // R2: a stop returns the engine to idle
   p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (state == ST_IDLE && !sda_oe));

   // R10: read strobe only with a sub-address accepted earlier
   p_re_needs_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> sub_vld);

endmodule

// File: rtl/twr_reg_slave.sv
module twr_reg_slave
   import twr_pkg::*;
#(
   parameter int              SYNC_STAGES = 2,
   parameter int              DATA_W      = 8,
   parameter int              ADDR_W      = 8,
   parameter int              DEV_W       = 7,
   parameter logic [DEV_W-1:0] INT_DEV     = 7'h20,
   parameter logic [DEV_W-1:0] SNS_DEV     = 7'h11,
   parameter int              INT_LO      = 'h80,
   parameter int              INT_HI      = 'hFF,
   parameter int              SNS_LO      = 'h00,
   parameter int              SNS_HI      = 'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              reg_sel,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);

   if (DATA_W != 8 || ADDR_W != DATA_W || DEV_W != DATA_W - 1) begin : g_bad_width
      $error("bus bytes, sub-addresses and device addresses must fit one 8-bit frame");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_p;
   logic              stop_p;
   logic [DEV_W-1:0]  dec_dev;
   logic [DATA_W-1:0] dec_sub;
   logic              dev_hit;
   twr_tgt_e          dev_tgt;
   logic [1:0]        win_ok;

   twr_line_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   twr_addr_decode #(
      .DEV_W   (DEV_W),
      .ADDR_W  (ADDR_W),
      .INT_DEV (INT_DEV),
      .SNS_DEV (SNS_DEV),
      .INT_LO  (INT_LO),
      .INT_HI  (INT_HI),
      .SNS_LO  (SNS_LO),
      .SNS_HI  (SNS_HI)
   ) i_dec (
      .dev_in  (dec_dev),
      .sub_in  (dec_sub),
      .dev_hit (dev_hit),
      .dev_tgt (dev_tgt),
      .win_ok  (win_ok)
   );

   twr_byte_engine #(
      .DATA_W (DATA_W),
      .DEV_W  (DEV_W)
   ) i_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_p   (start_p),
      .stop_p    (stop_p),
      .dec_dev   (dec_dev),
      .dec_sub   (dec_sub),
      .dev_hit   (dev_hit),
      .dev_tgt   (dev_tgt),
      .win_ok    (win_ok),
      .sda_oe    (sda_oe),
      .reg_sel   (reg_sel),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   // R4: a write strobe only ever targets the selected bank's window
   p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_sel ? (int'(reg_addr) >= SNS_LO && int'(reg_addr) <= SNS_HI)
                          : (int'(reg_addr) >= INT_LO && int'(reg_addr) <= INT_HI)));

   // R1: the strobes stay low straight after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!reg_we && !reg_re && !sda_oe));

endmodule

// File: tb/test_twr_reg_slave.sv
module test_twr_reg_slave;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic       reg_sel;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic       reg_re;
   logic [7:0] reg_rdata;

   logic [7:0] bank [0:511];
   logic [7:0] exp_bank [0:511];

   int n_chk = 0;
   int n_bad = 0;
   int we_cnt = 0;
   int re_cnt = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic       last_sel;
   logic [7:0] last_addr;
   logic [7:0] last_wd;
   logic       prev_oe = 1'b0;

   always #10 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = bank[{reg_sel, reg_addr}];

   twr_reg_slave i_twr_reg_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_sel   (reg_sel),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   // attached register banks and strobe monitor
   always @(negedge clk) begin
      if (reg_we) begin
         we_cnt++;
         last_sel  = reg_sel;
         last_addr = reg_addr;
         last_wd   = reg_wdata;
         bank[{reg_sel, reg_addr}] = reg_wdata;
      end
      if (reg_re) re_cnt++;
      if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_viol++;
      prev_oe = sda_oe;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit f_hit(input logic [7:0] d);
      return (d[7:1] == 7'h20) || (d[7:1] == 7'h11);
   endfunction

   function automatic bit f_tgt(input logic [7:0] d);
      return d[7:1] == 7'h11;
   endfunction

   function automatic bit f_win(input bit t, input logic [7:0] s);
      return t ? (s < 8'h80) : (s >= 8'h80);
   endfunction

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
      sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hq(); scl_m = 1'b1; hq(); scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      hq(); sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
      ack = !sda_line;
      scl_m = 1'b0; hq();
   endtask

   task automatic recv_byte(output logic [7:0] b, output bit rel);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hq(); scl_m = 1'b1; hq(); b[i] = sda_line; scl_m = 1'b0;
      end
      hq(); hq(); scl_m = 1'b1; hq();
      rel = sda_line;
      scl_m = 1'b0; hq();
   endtask

   task automatic do_write(input logic [7:0] dev, input logic [7:0] sub,
                           input logic [7:0] dat, output bit a1, output bit a2,
                           output bit a3);
      a1 = 0; a2 = 0; a3 = 0;
      bus_start();
      send_byte({dev[7:1], 1'b0}, a1);
      if (a1) send_byte(sub, a2);
      if (a2) send_byte(dat, a3);
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] dev, input logic [7:0] sub,
                          output bit a1, output bit a2, output bit a3,
                          output logic [7:0] d, output bit rel);
      a1 = 0; a2 = 0; a3 = 0; d = 8'h00; rel = 1'b1;
      bus_start();
      send_byte({dev[7:1], 1'b0}, a1);
      if (a1) send_byte(sub, a2);
      if (a2) begin
         bus_start();
         send_byte({dev[7:1], 1'b1}, a3);
         if (a3) recv_byte(d, rel);
      end
      bus_stop();
   endtask

   // full write with expected values from the bench model
   task automatic wr_chk(input string tag, input logic [7:0] dev,
                         input logic [7:0] sub, input logic [7:0] dat);
      bit a1, a2, a3, e1, e2;
      int w0;
      w0 = we_cnt;
      e1 = f_hit(dev);
      e2 = e1 && f_win(f_tgt(dev), sub);
      do_write(dev, sub, dat, a1, a2, a3);
      check({tag, " R3 dev ack"}, a1, e1);
      if (e1) check({tag, " R4 sub ack"}, a2, e2);
      if (e2) check({tag, " R5 data ack"}, a3, 1);
      check({tag, " R6 we count"}, we_cnt - w0, e2 ? 1 : 0);
      if (e2) begin
         check({tag, " R6 sel"}, last_sel, f_tgt(dev));
         check({tag, " R6 addr"}, last_addr, sub);
         check({tag, " R6 data"}, last_wd, dat);
         exp_bank[{f_tgt(dev), sub}] = dat;
      end
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] dev,
                         input logic [7:0] sub);
      bit a1, a2, a3, rel, e2;
      logic [7:0] d;
      int r0;
      r0 = re_cnt;
      e2 = f_hit(dev) && f_win(f_tgt(dev), sub);
      do_read(dev, sub, a1, a2, a3, d, rel);
      check({tag, " R3 dev ack"}, a1, f_hit(dev));
      check({tag, " R8 read ack"}, a3, e2);
      check({tag, " R8 re count"}, re_cnt - r0, e2 ? 1 : 0);
      if (e2) begin
         check({tag, " R8 data"}, d, exp_bank[{f_tgt(dev), sub}]);
         check({tag, " R10 released"}, rel, 1);
      end
   endtask

   initial begin
      for (int i = 0; i < 512; i++) begin
         bank[i]     = 8'(i * 37 + 5);
         exp_bank[i] = 8'(i * 37 + 5);
      end
   end

   initial begin
      bit a1, a2, a3, rel;
      logic [7:0] d;
      int w0, r0;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      check("R1 oe at reset", sda_oe, 0);
      check("R1 we at reset", reg_we, 0);
      check("R1 re at reset", reg_re, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 oe after reset", sda_oe, 0);

      wr_chk("int write", 8'h40, 8'h85, 8'hA7);
      wr_chk("sns write", 8'h22, 8'h10, 8'h3C);
      rd_chk("int read", 8'h40, 8'h85);
      rd_chk("sns read", 8'h22, 8'h10);
      wr_chk("bad dev", 8'h42, 8'h90, 8'h11);
      wr_chk("int low sub", 8'h40, 8'h10, 8'h22);
      wr_chk("sns high sub", 8'h22, 8'h90, 8'h33);
      wr_chk("int top", 8'h40, 8'hFF, 8'h5A);
      wr_chk("sns top", 8'h22, 8'h7F, 8'hC6);
      rd_chk("int top read", 8'h40, 8'hFF);
      rd_chk("sns edge read", 8'h22, 8'h7F);
      rd_chk("sns out window", 8'h22, 8'h80);

      // R7: second data byte refused
      w0 = we_cnt;
      bus_start();
      send_byte(8'h40, a1);
      send_byte(8'hA0, a2);
      send_byte(8'h61, a3);
      send_byte(8'h62, a1);
      bus_stop();
      check("R7 second byte nack", a1, 0);
      check("R7 single we", we_cnt - w0, 1);
      check("R7 kept first", last_wd, 8'h61);
      exp_bank[{1'b0, 8'hA0}] = 8'h61;

      // R2: stop partway through the address byte, then partway through data
      w0 = we_cnt;
      bus_start(); send_bits(8'h40, 4); hq(); bus_stop();
      bus_start();
      send_byte(8'h40, a1); send_byte(8'hB1, a2);
      send_bits(8'hEE, 5); hq(); bus_stop();
      check("R2 aborted data no we", we_cnt - w0, 0);
      // R2: start partway through the data byte abandons it too
      bus_start();
      send_byte(8'h22, a1); send_byte(8'h05, a2);
      send_bits(8'h99, 3); hq();
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
      send_byte(8'h40, a1);
      bus_stop();
      check("R2 restart dev ack", a1, 1);
      check("R2 restart no we", we_cnt - w0, 0);
      wr_chk("R2 recovery", 8'h40, 8'hB1, 8'h4D);

      // R10: read address without a sub-address in this transaction
      r0 = re_cnt;
      bus_start();
      send_byte(8'h41, a1);
      bus_stop();
      check("R10 bare read nack", a1, 0);
      check("R10 bare read no re", re_cnt - r0, 0);

      // back-to-back write then read of the same register
      wr_chk("R6 pair", 8'h22, 8'h00, 8'h81);
      rd_chk("R8 pair", 8'h22, 8'h00);

      for (int n = 0; n < 50; n++) begin
         logic [7:0] dev, sub, dat;
         int sel;
         sel = $urandom % 4;
         dev = (sel == 1) ? 8'h22 : (sel == 2) ? 8'($urandom) : 8'h40;
         sub = 8'($urandom);
         dat = 8'($urandom);
         if ($urandom % 2 == 0) wr_chk("rnd write", dev, sub, dat);
         else rd_chk("rnd read", dev, sub);
      end

      check("R9 oe moved with clock high", oe_viol, 0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule